// File: doc/BRIEF.md
# Per-Warp Floating-Point and Vector Status Register Unit

This block holds the control and status registers that the floating-point and vector datapaths of a multi-warp core consult, together with a handful of read-only identity registers and a machine scratch register. Software reaches every register through one request port that carries a register number, a warp index and a thread index. Reads return data in the same cycle. Writes take effect at the next clock edge.

Each warp owns one packed floating-point control byte. It holds five accrued exception flags and a three-bit dynamic rounding mode, and it can be accessed through three views: flags only, rounding mode only, or the whole byte. The execution units report exception flags on a side port, and the block ORs them into the owning warp's flags. A second side port takes an instruction's rounding field and returns the rounding mode that actually applies. Each (warp, thread) pair holds a one-bit vector saturation flag and a two-bit vector rounding mode, which are also visible together as one combined register.

Some machine status, trap and protection registers read as zero and drop writes. An access to a register number the block does not map, or a write to a read-only register, raises an illegal-access flag and changes nothing.

Top module: `fpv_csr_unit`

## Requirements
- R1: While reset is active, every warp's floating-point byte and every vector saturation and rounding field clear to zero, and the scratch register loads the value on `startup_arg`.
- R2: Reading 0x001 returns bits 4:0 of the addressed warp's floating-point byte (flags). Reading 0x002 returns bits 7:5 (rounding mode) in bits 2:0. Reading 0x003 returns all 8 bits. All other result bits are zero.
- R3: Writing 0x001 replaces only bits 4:0 with write data 4:0. Writing 0x002 replaces only bits 7:5 with write data 2:0. Writing 0x003 replaces the byte with write data 7:0.
- R4: The resolved rounding mode equals the rounding field unless the field is 7. For a field of 7 it equals bits 7:5 of the selected warp's byte.
- R5: A flag report ORs its five flags into bits 4:0 of the reported warp's byte. If a register write hits the same byte in the same cycle, the write is applied first and the flags are ORed on top.
- R6: Per warp and thread, 0x009 holds a 1-bit saturation flag (write data bit 0) and 0x00A holds a 2-bit vector rounding mode (write data 1:0). 0x00F reads {rounding, saturation} in bits 2:0, and a write to it takes saturation from bit 0 and rounding from bits 2:1.
- R7: 0xC22 reads as VLEN/8.
- R8: These registers are read-only:
  - 0xFC0 hart id = ((core_id × NUM_WARPS) + warp) × NUM_THREADS + thread
  - 0xFC1 thread index
  - 0xFC2 warp index
  - 0xFC3 core_id
  - 0xFC4 the addressed warp's active thread mask
  - 0xFC5 the active warp mask
- R9: 0x300, 0x302, 0x303, 0x304, 0x305, 0x341, 0x342, 0x3A0 and 0x3B0 read as zero without error. Writes to them are accepted and ignored.
- R10: 0x340 is a scratch register that reads back the last value written to it.
- R11: A valid request to an unmapped number, or a write to an R7/R8 register, sets `rd_illegal`, returns zero and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startup_arg | input | XLEN | Reset value of the scratch register |
| core_id | input | CORE_W | Index of the owning core |
| active_warps | input | NUM_WARPS | Active warp mask |
| active_threads | input | NUM_WARPS*NUM_THREADS | Per-warp thread masks, warp w at bits w*NUM_THREADS upward |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Register number |
| req_warp | input | WID_W | Warp index |
| req_thread | input | TID_W | Thread index |
| req_wdata | input | XLEN | Write data |
| rd_data | output | XLEN | Read data, same cycle |
| rd_illegal | output | 1 | Illegal access |
| fx_valid | input | 1 | Exception flag report |
| fx_warp | input | WID_W | Warp of the flag report |
| fx_flags | input | 5 | Reported flags |
| rm_warp | input | WID_W | Warp for rounding resolution |
| rm_field | input | 3 | Instruction rounding field |
| rm_resolved | output | 3 | Effective rounding mode |

## Verification
The bench builds the unit with four warps, four threads, a 32-bit data path, VLEN of 256 and the vector registers enabled. At this size the 16 per-thread vector entries and all four floating-point bytes are hit repeatedly by random traffic, and every warp's byte can hold a non-default rounding mode when a field of 7 resolves against it. Flag reports land on the same warp as a concurrent write often enough to exercise the write-then-OR ordering. The random core id and masks give many distinct hart id products.

// File: rtl/fpv_csr_pkg.sv
package fpv_csr_pkg;

   localparam logic [11:0] ADDR_FP_FLAGS = 12'h001;
   localparam logic [11:0] ADDR_FP_RMODE = 12'h002;
   localparam logic [11:0] ADDR_FP_ALL   = 12'h003;
   localparam logic [11:0] ADDR_V_SAT    = 12'h009;
   localparam logic [11:0] ADDR_V_RM     = 12'h00A;
   localparam logic [11:0] ADDR_V_STAT   = 12'h00F;
   localparam logic [11:0] ADDR_V_BYTES  = 12'hC22;
   localparam logic [11:0] ADDR_SCRATCH  = 12'h340;
   localparam logic [11:0] ADDR_HART     = 12'hFC0;
   localparam logic [11:0] ADDR_TID      = 12'hFC1;
   localparam logic [11:0] ADDR_WID      = 12'hFC2;
   localparam logic [11:0] ADDR_CID      = 12'hFC3;
   localparam logic [11:0] ADDR_TMASK    = 12'hFC4;
   localparam logic [11:0] ADDR_WMASK    = 12'hFC5;
   localparam logic [11:0] ADDR_M_STATUS = 12'h300;

   typedef enum logic [4:0] {
      SEL_NONE, SEL_FFLAGS, SEL_FRM, SEL_FALL, SEL_VSAT, SEL_VRM, SEL_VSTAT,
      SEL_VBYTES, SEL_SCRATCH, SEL_ZERO, SEL_HART, SEL_TID, SEL_WID, SEL_CID,
      SEL_TMASK, SEL_WMASK
   } csr_sel_e;

   typedef enum logic [1:0] {FPW_FLAGS, FPW_RMODE, FPW_ALL} fp_wkind_e;
   typedef enum logic [1:0] {VW_SAT, VW_RM, VW_BOTH} vec_wkind_e;

endpackage

// File: rtl/fpv_csr_decode.sv
module fpv_csr_decode
   import fpv_csr_pkg::*;
#(
   parameter bit VEC_EN = 1'b1
) (
   input  logic [11:0] addr,
   output csr_sel_e    sel,
   output logic        rd_ok,
   output logic        wr_ok
);
   logic vec_ok;

   generate
      if (VEC_EN) begin : g_vec
         assign vec_ok = 1'b1;
      end else begin : g_novec
         assign vec_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      sel = SEL_NONE;
      unique case (addr)
         ADDR_FP_FLAGS: sel = SEL_FFLAGS;
         ADDR_FP_RMODE: sel = SEL_FRM;
         ADDR_FP_ALL:   sel = SEL_FALL;
         ADDR_V_SAT:    sel = vec_ok ? SEL_VSAT   : SEL_NONE;
         ADDR_V_RM:     sel = vec_ok ? SEL_VRM    : SEL_NONE;
         ADDR_V_STAT:   sel = vec_ok ? SEL_VSTAT  : SEL_NONE;
         ADDR_V_BYTES:  sel = vec_ok ? SEL_VBYTES : SEL_NONE;
         ADDR_SCRATCH:  sel = SEL_SCRATCH;
         ADDR_HART:     sel = SEL_HART;
         ADDR_TID:      sel = SEL_TID;
         ADDR_WID:      sel = SEL_WID;
         ADDR_CID:      sel = SEL_CID;
         ADDR_TMASK:    sel = SEL_TMASK;
         ADDR_WMASK:    sel = SEL_WMASK;
         12'h300, 12'h302, 12'h303, 12'h304, 12'h305,
         12'h341, 12'h342, 12'h3A0, 12'h3B0: sel = SEL_ZERO;
         default:       sel = SEL_NONE;
      endcase
   end

   assign rd_ok = (sel != SEL_NONE);
   assign wr_ok = rd_ok && !(sel inside {SEL_VBYTES, SEL_HART, SEL_TID, SEL_WID,
                                         SEL_CID, SEL_TMASK, SEL_WMASK});
endmodule

// File: rtl/fpv_fp_bank.sv
module fpv_fp_bank
   import fpv_csr_pkg::*;
#(
   parameter int NUM_WARPS = 4,
   localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [WID_W-1:0]       wr_warp,
   input  fp_wkind_e              wr_kind,
   input  logic [7:0]             wr_data,
   input  logic                   fx_valid,
   input  logic [WID_W-1:0]       fx_warp,
   input  logic [4:0]             fx_flags,
   input  logic [WID_W-1:0]       rd_warp,
   output logic [7:0]             rd_byte,
   input  logic [WID_W-1:0]       rm_warp,
   input  logic [2:0]             rm_field,
   output logic [2:0]             rm_resolved,
   output logic [NUM_WARPS*8-1:0] state_flat
);
   logic [7:0] fp_q [NUM_WARPS];

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
      logic [7:0] nxt;
      always_comb begin
         nxt = fp_q[w];
         if (wr_en && (wr_warp == WID_W'(w))) begin
            unique case (wr_kind)
               FPW_FLAGS: nxt[4:0] = wr_data[4:0];
               FPW_RMODE: nxt[7:5] = wr_data[2:0];
               default:   nxt      = wr_data;
            endcase
         end
         if (fx_valid && (fx_warp == WID_W'(w)))
            nxt[4:0] = nxt[4:0] | fx_flags;
      end
      always_ff @(posedge clk) begin
         if (!rst_n) fp_q[w] <= '0;
         else        fp_q[w] <= nxt;
      end
      assign state_flat[w*8 +: 8] = fp_q[w];
   end

   assign rd_byte     = fp_q[rd_warp];
   assign rm_resolved = (rm_field == 3'd7) ? fp_q[rm_warp][7:5] : rm_field;
endmodule

// File: rtl/fpv_vec_bank.sv
module fpv_vec_bank
   import fpv_csr_pkg::*;
#(
   parameter int NUM_WARPS   = 4,
   parameter int NUM_THREADS = 4,
   localparam int ENTRIES    = NUM_WARPS * NUM_THREADS,
   localparam int IDX_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     idx,
   input  vec_wkind_e           wr_kind,
   input  logic [2:0]           wr_data,
   output logic                 rd_sat,
   output logic [1:0]           rd_rm,
   output logic [ENTRIES*3-1:0] state_flat
);
   logic [2:0] ent_q [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_q[e] <= '0;
         end else if (wr_en && (idx == IDX_W'(e))) begin
            unique case (wr_kind)
               VW_SAT:  ent_q[e][0]   <= wr_data[0];
               VW_RM:   ent_q[e][2:1] <= wr_data[1:0];
               default: ent_q[e]      <= wr_data;
            endcase
         end
      end
      assign state_flat[e*3 +: 3] = ent_q[e];
   end

   assign rd_sat = ent_q[idx][0];
   assign rd_rm  = ent_q[idx][2:1];
endmodule

// File: rtl/fpv_csr_unit.sv
module fpv_csr_unit
   import fpv_csr_pkg::*;
#(
   parameter int  NUM_WARPS   = 4,
   parameter int  NUM_THREADS = 4,
   parameter int  XLEN        = 32,
   parameter int  VLEN        = 256,
   parameter int  CORE_W      = 8,
   parameter bit  VEC_EN      = 1'b1,
   localparam int WID_W       = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
   localparam int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
   localparam int ENTRIES     = NUM_WARPS * NUM_THREADS
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [XLEN-1:0]              startup_arg,
   input  logic [CORE_W-1:0]            core_id,
   input  logic [NUM_WARPS-1:0]         active_warps,
   input  logic [NUM_WARPS*NUM_THREADS-1:0] active_threads,
   input  logic                         req_valid,
   input  logic                         req_write,
   input  logic [11:0]                  req_addr,
   input  logic [WID_W-1:0]             req_warp,
   input  logic [TID_W-1:0]             req_thread,
   input  logic [XLEN-1:0]              req_wdata,
   output logic [XLEN-1:0]              rd_data,
   output logic                         rd_illegal,
   input  logic                         fx_valid,
   input  logic [WID_W-1:0]             fx_warp,
   input  logic [4:0]                   fx_flags,
   input  logic [WID_W-1:0]             rm_warp,
   input  logic [2:0]                   rm_field,
   output logic [2:0]                   rm_resolved
);
   localparam int VBYTES = VLEN / 8;

   if (XLEN < 8 || NUM_WARPS > XLEN || NUM_THREADS > XLEN) begin : g_bad_width
      $error("fpv_csr_unit: XLEN too narrow for masks or FP byte");
   end
   if ((VLEN % 8) != 0 || VLEN < 8) begin : g_bad_vlen
      $error("fpv_csr_unit: VLEN must be a positive multiple of 8");
   end
   if ((1 << WID_W) != NUM_WARPS && NUM_WARPS != 1) begin : g_bad_warps
      $error("fpv_csr_unit: NUM_WARPS must be a power of two");
   end
   if ((1 << TID_W) != NUM_THREADS && NUM_THREADS != 1) begin : g_bad_threads
      $error("fpv_csr_unit: NUM_THREADS must be a power of two");
   end

   csr_sel_e sel;
   logic     rd_ok, wr_ok, acc_ok, do_wr;

   fpv_csr_decode #(.VEC_EN(VEC_EN)) i_decode (
      .addr (req_addr), .sel (sel), .rd_ok (rd_ok), .wr_ok (wr_ok)
   );

   assign acc_ok     = req_write ? wr_ok : rd_ok;
   assign rd_illegal = req_valid && !acc_ok;
   assign do_wr      = req_valid && req_write && wr_ok;

   // floating-point control bytes
   logic                   fp_wr;
   fp_wkind_e              fp_kind;
   logic [7:0]             fp_byte;
   logic [NUM_WARPS*8-1:0] fp_flat;

   assign fp_wr   = do_wr && (sel inside {SEL_FFLAGS, SEL_FRM, SEL_FALL});
   assign fp_kind = (sel == SEL_FFLAGS) ? FPW_FLAGS :
                    (sel == SEL_FRM)    ? FPW_RMODE : FPW_ALL;

   fpv_fp_bank #(.NUM_WARPS(NUM_WARPS)) i_fp (
      .clk (clk), .rst_n (rst_n),
      .wr_en (fp_wr), .wr_warp (req_warp), .wr_kind (fp_kind),
      .wr_data (req_wdata[7:0]),
      .fx_valid (fx_valid), .fx_warp (fx_warp), .fx_flags (fx_flags),
      .rd_warp (req_warp), .rd_byte (fp_byte),
      .rm_warp (rm_warp), .rm_field (rm_field), .rm_resolved (rm_resolved),
      .state_flat (fp_flat)
   );

   // vector status entries, one per warp and thread
   logic                 v_wr, v_sat;
   vec_wkind_e           v_kind;
   logic [1:0]           v_rm;
   logic [ENTRIES*3-1:0] vec_flat;

   assign v_wr   = do_wr && (sel inside {SEL_VSAT, SEL_VRM, SEL_VSTAT});
   assign v_kind = (sel == SEL_VSAT) ? VW_SAT :
                   (sel == SEL_VRM)  ? VW_RM  : VW_BOTH;

   fpv_vec_bank #(.NUM_WARPS(NUM_WARPS), .NUM_THREADS(NUM_THREADS)) i_vec (
      .clk (clk), .rst_n (rst_n),
      .wr_en (v_wr), .idx ({req_warp, req_thread}), .wr_kind (v_kind),
      .wr_data (req_wdata[2:0]),
      .rd_sat (v_sat), .rd_rm (v_rm), .state_flat (vec_flat)
   );

   // scratch register
   logic [XLEN-1:0] scratch_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                            scratch_q <= startup_arg;
      else if (do_wr && sel == SEL_SCRATCH)  scratch_q <= req_wdata;
   end

   // read mux
   logic [XLEN-1:0] hart_id;
   assign hart_id = (XLEN'(core_id) * XLEN'(NUM_WARPS) + XLEN'(req_warp))
                    * XLEN'(NUM_THREADS) + XLEN'(req_thread);

   always_comb begin
      rd_data = '0;
      if (req_valid && acc_ok) begin
         unique case (sel)
            SEL_FFLAGS:  rd_data[4:0] = fp_byte[4:0];
            SEL_FRM:     rd_data[2:0] = fp_byte[7:5];
            SEL_FALL:    rd_data[7:0] = fp_byte;
            SEL_VSAT:    rd_data[0]   = v_sat;
            SEL_VRM:     rd_data[1:0] = v_rm;
            SEL_VSTAT:   rd_data[2:0] = {v_rm, v_sat};
            SEL_VBYTES:  rd_data      = XLEN'(VBYTES);
            SEL_SCRATCH: rd_data      = scratch_q;
            SEL_HART:    rd_data      = hart_id;
            SEL_TID:     rd_data      = XLEN'(req_thread);
            SEL_WID:     rd_data      = XLEN'(req_warp);
            SEL_CID:     rd_data      = XLEN'(core_id);
            SEL_TMASK:   rd_data[NUM_THREADS-1:0] =
                            active_threads[req_warp*NUM_THREADS +: NUM_THREADS];
            SEL_WMASK:   rd_data[NUM_WARPS-1:0] = active_warps;
            default:     rd_data      = '0;
         endcase
      end
   end
endmodule

// File: rtl/fpv_csr_checker.sv
module fpv_csr_checker
   import fpv_csr_pkg::*;
#(
   parameter int NUM_WARPS   = 4,
   parameter int NUM_THREADS = 4,
   parameter int XLEN        = 32,
   localparam int WID_W      = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic                               req_valid,
   input logic                               req_write,
   input logic [11:0]                        req_addr,
   input logic [WID_W-1:0]                   req_warp,
   input logic                               fx_valid,
   input logic [WID_W-1:0]                   fx_warp,
   input logic [4:0]                         fx_flags,
   input logic [2:0]                         rm_field,
   input logic [2:0]                         rm_resolved,
   input logic                               rd_illegal,
   input logic [XLEN-1:0]                    rd_data,
   input logic [NUM_WARPS*8-1:0]             fp_flat,
   input logic [NUM_WARPS*NUM_THREADS*3-1:0] vec_flat,
   input logic [XLEN-1:0]                    scratch_q
);
   // a rounding-mode view write leaves the flags of that warp untouched
   assert_rmode_keeps_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr == ADDR_FP_RMODE && !fx_valid)
      |=> fp_flat[{$past(req_warp), 3'b000} +: 5] ==
          $past(fp_flat[{req_warp, 3'b000} +: 5]));

   // reported flags are present in the warp's byte afterwards
   assert_flags_accrue_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fx_valid |=> ((fp_flat[{$past(fx_warp), 3'b000} +: 5] & $past(fx_flags))
                    == $past(fx_flags)));

   assert_illegal_no_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_illegal && !fx_valid)
      |=> ($stable(fp_flat) && $stable(vec_flat) && $stable(scratch_q)));

   assert_illegal_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rd_illegal |-> rd_data == '0);

   assert_static_rm_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rm_field != 3'd7) |-> rm_resolved == rm_field);

   assert_zero_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr == ADDR_M_STATUS)
      |-> (rd_data == '0 && !rd_illegal));
endmodule

bind fpv_csr_unit fpv_csr_checker #(
   .NUM_WARPS (NUM_WARPS), .NUM_THREADS (NUM_THREADS), .XLEN (XLEN)
) i_fpv_csr_checker (
   .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
   .req_addr (req_addr), .req_warp (req_warp), .fx_valid (fx_valid),
   .fx_warp (fx_warp), .fx_flags (fx_flags), .rm_field (rm_field),
   .rm_resolved (rm_resolved), .rd_illegal (rd_illegal), .rd_data (rd_data),
   .fp_flat (fp_flat), .vec_flat (vec_flat), .scratch_q (scratch_q)
);

// File: tb/test_fpv_csr_unit.sv
module test_fpv_csr_unit;
   import fpv_csr_pkg::*;

   localparam int NW = 4, NT = 4, XL = 32, VL = 256, CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [XL-1:0] startup_arg = 32'hCAFE_0123;
   logic [CW-1:0] core_id = '0;
   logic [NW-1:0] active_warps = '0;
   logic [NW*NT-1:0] active_threads = '0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [11:0]   req_addr = '0;
   logic [1:0]    req_warp = '0, req_thread = '0;
   logic [XL-1:0] req_wdata = '0;
   logic [XL-1:0] rd_data;
   logic          rd_illegal;
   logic          fx_valid = 1'b0;
   logic [1:0]    fx_warp = '0;
   logic [4:0]    fx_flags = '0;
   logic [1:0]    rm_warp = '0;
   logic [2:0]    rm_field = '0;
   logic [2:0]    rm_resolved;

   always #10 clk = ~clk;

   fpv_csr_unit #(.NUM_WARPS(NW), .NUM_THREADS(NT), .XLEN(XL), .VLEN(VL),
                  .CORE_W(CW), .VEC_EN(1'b1)) i_fpv_csr_unit (
      .clk (clk), .rst_n (rst_n), .startup_arg (startup_arg), .core_id (core_id),
      .active_warps (active_warps), .active_threads (active_threads),
      .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
      .req_warp (req_warp), .req_thread (req_thread), .req_wdata (req_wdata),
      .rd_data (rd_data), .rd_illegal (rd_illegal),
      .fx_valid (fx_valid), .fx_warp (fx_warp), .fx_flags (fx_flags),
      .rm_warp (rm_warp), .rm_field (rm_field), .rm_resolved (rm_resolved)
   );

   int n_checks = 0, n_fail = 0;
   bit done = 1'b0;

   // reference state
   logic [7:0]    m_fp  [NW];
   logic          m_sat [NW*NT];
   logic [1:0]    m_vrm [NW*NT];
   logic [XL-1:0] m_scr;

   task automatic check(string req, logic [XL-1:0] act, logic [XL-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h (addr 0x%0h)", req, act, exp, req_addr);
      end
   endtask

   function automatic bit is_zero_reg(logic [11:0] a);
      return a inside {12'h300, 12'h302, 12'h303, 12'h304, 12'h305,
                       12'h341, 12'h342, 12'h3A0, 12'h3B0};
   endfunction

   function automatic bit is_ro_reg(logic [11:0] a);
      return a inside {12'hC22, 12'hFC0, 12'hFC1, 12'hFC2, 12'hFC3, 12'hFC4, 12'hFC5};
   endfunction

   function automatic bit is_rw_reg(logic [11:0] a);
      return a inside {12'h001, 12'h002, 12'h003, 12'h009, 12'h00A, 12'h00F, 12'h340};
   endfunction

   function automatic logic [XL-1:0] model_read(logic [11:0] a, int w, int t);
      int e = w * NT + t;
      case (a)
         12'h001: return XL'(m_fp[w][4:0]);
         12'h002: return XL'(m_fp[w][7:5]);
         12'h003: return XL'(m_fp[w]);
         12'h009: return XL'(m_sat[e]);
         12'h00A: return XL'(m_vrm[e]);
         12'h00F: return XL'({m_vrm[e], m_sat[e]});
         12'hC22: return XL'(VL / 8);
         12'h340: return m_scr;
         12'hFC0: return XL'((int'(core_id) * NW + w) * NT + t);
         12'hFC1: return XL'(t);
         12'hFC2: return XL'(w);
         12'hFC3: return XL'(core_id);
         12'hFC4: return XL'(active_threads[w*NT +: NT]);
         12'hFC5: return XL'(active_warps);
         default: return '0;
      endcase
   endfunction

   // one request cycle: drive at negedge, check combinational outputs, update model
   task automatic op(bit wr, logic [11:0] a, int w, int t, logic [XL-1:0] wd,
                     bit fxv, int fxw, logic [4:0] fxf, logic [2:0] rmf, int rmw);
      bit legal;
      logic [2:0] exp_rm;
      int e = w * NT + t;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a;
      req_warp = 2'(w); req_thread = 2'(t); req_wdata = wd;
      fx_valid = fxv; fx_warp = 2'(fxw); fx_flags = fxf;
      rm_field = rmf; rm_warp = 2'(rmw);
      #2;
      legal = wr ? (is_rw_reg(a) || is_zero_reg(a))
                 : (is_rw_reg(a) || is_zero_reg(a) || is_ro_reg(a));
      // R11: illegal flag and zero data
      check(legal ? "R11 legal access" : "R11 illegal flag", XL'(rd_illegal), XL'(!legal));
      if (!legal) check("R11 illegal data zero", rd_data, '0);
      else if (!wr) begin
         if (is_zero_reg(a)) check("R9 zero read", rd_data, '0);
         else if (is_ro_reg(a)) check("R7 R8 identity read", rd_data, model_read(a, w, t));
         else check("R2 R6 R10 read", rd_data, model_read(a, w, t));
      end
      // R4: rounding resolution
      exp_rm = (rmf == 3'd7) ? m_fp[rmw][7:5] : rmf;
      check("R4 rounding resolve", XL'(rm_resolved), XL'(exp_rm));
      @(posedge clk);
      if (wr && legal) begin
         case (a)
            12'h001: m_fp[w][4:0] = wd[4:0];          // R3
            12'h002: m_fp[w][7:5] = wd[2:0];          // R3
            12'h003: m_fp[w]      = wd[7:0];          // R3
            12'h009: m_sat[e]     = wd[0];            // R6
            12'h00A: m_vrm[e]     = wd[1:0];          // R6
            12'h00F: begin m_sat[e] = wd[0]; m_vrm[e] = wd[2:1]; end
            12'h340: m_scr        = wd;               // R10
            default: ;                                // R9 ignored
         endcase
      end
      if (fxv) m_fp[fxw][4:0] = m_fp[fxw][4:0] | fxf; // R5 after write
   endtask

   task automatic rd(logic [11:0] a, int w, int t);
      op(1'b0, a, w, t, '0, 1'b0, 0, 5'd0, 3'd0, 0);
   endtask

   task automatic wr(logic [11:0] a, int w, int t, logic [XL-1:0] d);
      op(1'b1, a, w, t, d, 1'b0, 0, 5'd0, 3'd0, 0);
   endtask

   localparam logic [11:0] POOL [26] = '{
      12'h001, 12'h002, 12'h003, 12'h009, 12'h00A, 12'h00F, 12'hC22, 12'h340,
      12'hFC0, 12'hFC1, 12'hFC2, 12'hFC3, 12'hFC4, 12'hFC5,
      12'h300, 12'h302, 12'h303, 12'h304, 12'h305, 12'h341, 12'h342, 12'h3A0, 12'h3B0,
      12'h123, 12'h004, 12'hFC6};

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'd2024);
      for (int w = 0; w < NW; w++) m_fp[w] = '0;
      for (int e = 0; e < NW*NT; e++) begin m_sat[e] = 1'b0; m_vrm[e] = '0; end
      m_scr = startup_arg;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      startup_arg = 32'h0;   // must not affect scratch after reset

      // R1: reset state
      rd(ADDR_SCRATCH, 0, 0);
      check("R1 scratch reset", rd_data, 32'hCAFE_0123);
      rd(ADDR_FP_ALL, 3, 0);
      check("R1 fp byte reset", rd_data, '0);
      rd(ADDR_V_STAT, 2, 3);
      check("R1 vector reset", rd_data, '0);

      // R3: views replace only their bits
      wr(ADDR_FP_ALL, 1, 0, 32'hFFFF_FFFF);
      rd(ADDR_FP_ALL, 1, 0);
      check("R3 full view masked", rd_data, 32'hFF);
      wr(ADDR_FP_FLAGS, 1, 0, 32'h0000_0000);
      rd(ADDR_FP_ALL, 1, 0);
      check("R3 flags write keeps rmode", rd_data, 32'hE0);
      wr(ADDR_FP_RMODE, 1, 0, 32'h0000_0002);
      rd(ADDR_FP_ALL, 1, 0);
      check("R3 rmode write", rd_data, 32'h40);

      // R4: field 7 picks stored mode
      op(1'b0, ADDR_FP_RMODE, 1, 0, '0, 1'b0, 0, 5'd0, 3'd7, 1);
      check("R4 dynamic mode", XL'(rm_resolved), 32'd2);

      // R5: write and flag report on the same warp in the same cycle
      op(1'b1, ADDR_FP_FLAGS, 2, 0, 32'h01, 1'b1, 2, 5'h10, 3'd0, 0);
      rd(ADDR_FP_FLAGS, 2, 0);
      check("R5 write then OR", rd_data, 32'h11);

      // R6: combined vector view split
      wr(ADDR_V_STAT, 3, 2, 32'h5);
      rd(ADDR_V_RM, 3, 2);
      check("R6 combined write rounding", rd_data, 32'h2);
      rd(ADDR_V_SAT, 3, 2);
      check("R6 combined write saturation", rd_data, 32'h1);

      // R8: hart id
      core_id = 8'd3;
      rd(ADDR_HART, 2, 1);
      check("R8 hart id", rd_data, 32'd57);

      // R7 / R11: write to read-only
      wr(ADDR_V_BYTES, 0, 0, 32'h99);
      rd(ADDR_V_BYTES, 0, 0);
      check("R7 vlenb", rd_data, 32'd32);

      // R9: write to zero register ignored, scratch untouched
      wr(12'h341, 0, 0, 32'hDEAD_BEEF);
      rd(12'h341, 0, 0);
      check("R9 write ignored", rd_data, '0);

      // random traffic
      for (int i = 0; i < 4000; i++) begin
         core_id        = CW'($urandom);
         active_warps   = NW'($urandom);
         active_threads = (NW*NT)'($urandom);
         op(($urandom % 3) == 0, POOL[$urandom % 26], int'($urandom % NW),
            int'($urandom % NT), $urandom, ($urandom % 4) == 0,
            int'($urandom % NW), 5'($urandom), 3'($urandom), int'($urandom % NW));
      end

      @(negedge clk);
      req_valid = 1'b0; fx_valid = 1'b0;
      #2;
      check("R11 idle no error", XL'(rd_illegal), '0);

      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1'b1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule